// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block Memory

This block is a synchronous memory with two fully independent ports, A and B, over one shared store of 16384 data bits and 2048 parity bits. Each port has its own clock, synchronous output reset, access enable, write strobe, location input, write data, write parity, read data and read parity. The data width of each port is fixed at elaboration, and the two ports need not agree. A value stored as several narrow words through one port can be fetched as one packed wide word through the other, and a wide word can be fetched back in narrow pieces.

Parity lanes, one bit per data byte, are present only on ports that are a byte or wider. Each port also has an elaboration-time write view. With the new-data view, a write returns the value being written on the read data output. With the old-data view, a write returns the contents that were at that location before the write. Every read result passes through a single output register.

Top module: `mixwidth_dpram`

## Requirements
- R1: A port's data width W must be 1, 2, 4, 8, 16 or 32. Its parity width is W/8 when W is 8 or more. Its location input is 14 − log2(W) bits wide, so location 2^(14−log2 W) − 1 reaches the top W bits of the data store. A port narrower than 8 has a 1-bit parity input that is ignored and a 1-bit parity output that always reads 0.
- R2: When the enable and the write strobe are both high at a rising clock edge, the write data (and the write parity, on ports with parity) is stored at the given location. A later read of that location returns it.
- R3: When the enable is high and the write strobe is low, the port's read outputs show the stored word one clock edge later.
- R4: When the enable is low, the read outputs hold their value and nothing is stored, whatever the write strobe and the data inputs are.
- R5: On a port with the new-data view, an enabled write puts the written data on the read data output at the same edge.
- R6: On a port with the old-data view, an enabled write puts the previous contents of the location on the read outputs.
- R7: Lanes are packed little-endian. At width W, location a covers data bits [W*a+W−1 : W*a] of the flat store. A wide read therefore returns the narrow words in ascending location order, with the lowest location in the least significant bits.
- R8: Parity bit k belongs to data byte k of the flat store. A port of width W ≥ 8 at location a covers parity bits [P*a+P−1 : P*a], where P = W/8. Writes through ports narrower than 8 never change parity.
- R9: A high output reset at a rising edge clears that port's read data and read parity to 0. It does not stop a write that is enabled on the same edge, and it leaves the store unchanged.
- R10: The ports act independently. Writes at the same edge to disjoint bits both take effect. A read at the same edge as a write by the other port to those bits returns the contents from before the edge.
- R11: Before the first write, every data and parity bit of the store reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock, rising edge active |
| a_srst | input | 1 | Port A synchronous clear of the read outputs |
| a_act | input | 1 | Port A access enable |
| a_write | input | 1 | Port A write strobe |
| a_loc | input | 14 − log2(A_DW) | Port A location |
| a_wdata | input | A_DW | Port A write data |
| a_wpar | input | max(A_DW/8, 1) | Port A write parity (ignored when A_DW < 8) |
| a_rdata | output | A_DW | Port A registered read data |
| a_rpar | output | max(A_DW/8, 1) | Port A registered read parity (0 when A_DW < 8) |
| b_clk | input | 1 | Port B clock, rising edge active |
| b_srst | input | 1 | Port B synchronous clear of the read outputs |
| b_act | input | 1 | Port B access enable |
| b_write | input | 1 | Port B write strobe |
| b_loc | input | 14 − log2(B_DW) | Port B location |
| b_wdata | input | B_DW | Port B write data |
| b_wpar | input | max(B_DW/8, 1) | Port B write parity (ignored when B_DW < 8) |
| b_rdata | output | B_DW | Port B registered read data |
| b_rpar | output | max(B_DW/8, 1) | Port B registered read parity (0 when B_DW < 8) |

## Verification
Several port-local rules are checked by the assertions on every cycle:
- the read outputs hold while the port is idle;
- the outputs clear after an output reset;
- a new-data port echoes what it writes;
- an old-data port returns the same value on a write as on the read just before it;
- a write followed by a read of the same location returns the written word.

Width conversion between the ports, little-endian lane order, the parity-per-byte mapping, the zero contents at power-up and the read of pre-edge contents when the other port writes on the same edge all involve both ports and the shared store. Only the bench's flat-bit reference model can show these, through its directed cross-width scenarios and a mixed random phase with disjoint write regions.

// File: rtl/mwdp_pkg.sv
package mwdp_pkg;

  localparam int CAP_BITS = 16384;
  localparam int ROW_W    = 32;
  localparam int ROW_PW   = ROW_W / 8;
  localparam int ROWS     = CAP_BITS / ROW_W;
  localparam int ROW_AW   = $clog2(ROWS);

  // What the read port returns on a write cycle.
  typedef enum logic {
    VIEW_NEW = 1'b0,
    VIEW_OLD = 1'b1
  } wr_view_e;

  // Parity lanes carried by a port of data width dw.
  function automatic int par_w(input int dw);
    return (dw >= 8) ? dw / 8 : 0;
  endfunction

  // Physical width of the parity pins (at least one bit).
  function automatic int par_pin_w(input int dw);
    return (dw >= 8) ? dw / 8 : 1;
  endfunction

  // Location bits: 14 - log2(dw) for the fixed capacity.
  function automatic int loc_w(input int dw);
    return $clog2(CAP_BITS / dw);
  endfunction

  // Bits selecting a lane within one storage row.
  function automatic int lane_w(input int dw);
    return $clog2(ROW_W / dw);
  endfunction

endpackage

// File: rtl/mwdp_locmap.sv
module mwdp_locmap import mwdp_pkg::*; #(
  parameter  int DW   = 8,
  localparam int LOCW = loc_w(DW),
  localparam int LW   = lane_w(DW),
  localparam int LNW  = (LW == 0) ? 1 : LW
) (
  input  logic [LOCW-1:0]   loc,
  output logic [ROW_AW-1:0] row,
  output logic [LNW-1:0]    lane
);

  generate
    if (LW == 0) begin : g_full_row
      assign row  = loc;
      assign lane = '0;
    end else begin : g_split_row
      assign row  = loc[LOCW-1:LW];
      assign lane = loc[LW-1:0];
    end
  endgenerate

endmodule

// File: rtl/mwdp_port.sv
module mwdp_port import mwdp_pkg::*; #(
  parameter  int       DW   = 8,
  parameter  wr_view_e VIEW = VIEW_NEW,
  localparam int LOCW = loc_w(DW),
  localparam int PW   = par_w(DW),
  localparam int PPW  = par_pin_w(DW),
  localparam int LW   = lane_w(DW),
  localparam int LNW  = (LW == 0) ? 1 : LW
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              en,
  input  logic              wr,
  input  logic [LOCW-1:0]   loc,
  input  logic [DW-1:0]     wdata,
  input  logic [PPW-1:0]    wpar,
  output logic [DW-1:0]     rdata,
  output logic [PPW-1:0]    rpar,
  output logic [ROW_AW-1:0] my_row,      // row this port addresses
  input  logic [ROW_W-1:0]  peer_d,      // peer bank data at my_row
  input  logic [ROW_PW-1:0] peer_p,      // peer bank parity at my_row
  input  logic [ROW_AW-1:0] xrow,        // row the peer addresses
  output logic [ROW_W-1:0]  xrow_d,      // own bank data at xrow
  output logic [ROW_PW-1:0] xrow_p,      // own bank parity at xrow
  input  logic              peer_wr      // peer writes this cycle
);

  // Own half of the XOR pair; logical content = own ^ peer.
  logic [ROW_W-1:0]  bank_d [ROWS];
  logic [ROW_PW-1:0] bank_p [ROWS];

  initial begin
    for (int i = 0; i < ROWS; i++) begin
      bank_d[i] = '0;
      bank_p[i] = '0;
    end
  end

  assign xrow_d = bank_d[xrow];
  assign xrow_p = bank_p[xrow];

  logic [LNW-1:0] lane;

  mwdp_locmap #(.DW(DW)) u_map (
    .loc  (loc),
    .row  (my_row),
    .lane (lane)
  );

  logic [ROW_W-1:0] view_d;
  logic [DW-1:0]    cur_word;
  logic [PPW-1:0]   cur_par;
  logic [PPW-1:0]   new_par;
  logic             wr_fire;

  assign view_d   = bank_d[my_row] ^ peer_d;
  assign cur_word = view_d[int'(lane)*DW +: DW];
  assign wr_fire  = en & wr;

  always_ff @(posedge clk) begin
    if (wr_fire)
      bank_d[my_row][int'(lane)*DW +: DW] <= wdata ^ peer_d[int'(lane)*DW +: DW];
  end

  generate
    if (PW > 0) begin : g_par
      logic [ROW_PW-1:0] view_p;
      assign view_p  = bank_p[my_row] ^ peer_p;
      assign cur_par = view_p[int'(lane)*PW +: PW];
      assign new_par = wpar;
      always_ff @(posedge clk) begin
        if (wr_fire)
          bank_p[my_row][int'(lane)*PW +: PW] <= wpar ^ peer_p[int'(lane)*PW +: PW];
      end
    end else begin : g_no_par
      logic unused_par;
      assign unused_par = ^{wpar, peer_p};
      assign cur_par    = '0;
      assign new_par    = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (srst) begin
      rdata <= '0;
      rpar  <= '0;
    end else if (en) begin
      if (wr && (VIEW == VIEW_NEW)) begin
        rdata <= wdata;
        rpar  <= new_par;
      end else begin
        rdata <= cur_word;
        rpar  <= cur_par;
      end
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk) disable iff (srst)
    $fell(srst) |-> (rdata == '0 && rpar == '0))
    else $error("outputs not cleared after reset"); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (srst)
    !en |=> ($stable(rdata) && $stable(rpar)))
    else $error("read outputs moved while idle"); // R4

  AST_NEW_ECHO: assert property (@(posedge clk) disable iff (srst)
    ((VIEW == VIEW_NEW) && en && wr) |=> (rdata == $past(wdata)))
    else $error("write did not echo new data"); // R5

  AST_OLD_KEEP: assert property (@(posedge clk) disable iff (srst)
    ((VIEW == VIEW_OLD) && en && !wr && !peer_wr ##1 en && wr && (loc == $past(loc)))
      |=> (rdata == $past(rdata)))
    else $error("write did not return previous contents"); // R6

  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (srst)
    (en && wr && !peer_wr ##1 en && !wr && (loc == $past(loc)))
      |=> (rdata == $past(wdata, 2)))
    else $error("read after write returned wrong word"); // R2

endmodule

// File: rtl/mixwidth_dpram.sv
module mixwidth_dpram import mwdp_pkg::*; #(
  parameter  int       A_DW   = 8,
  parameter  wr_view_e A_VIEW = VIEW_NEW,
  parameter  int       B_DW   = 32,
  parameter  wr_view_e B_VIEW = VIEW_OLD,
  localparam int A_LOCW = loc_w(A_DW),
  localparam int B_LOCW = loc_w(B_DW),
  localparam int A_PPW  = par_pin_w(A_DW),
  localparam int B_PPW  = par_pin_w(B_DW)
) (
  input  logic              a_clk,
  input  logic              a_srst,
  input  logic              a_act,
  input  logic              a_write,
  input  logic [A_LOCW-1:0] a_loc,
  input  logic [A_DW-1:0]   a_wdata,
  input  logic [A_PPW-1:0]  a_wpar,
  output logic [A_DW-1:0]   a_rdata,
  output logic [A_PPW-1:0]  a_rpar,
  input  logic              b_clk,
  input  logic              b_srst,
  input  logic              b_act,
  input  logic              b_write,
  input  logic [B_LOCW-1:0] b_loc,
  input  logic [B_DW-1:0]   b_wdata,
  input  logic [B_PPW-1:0]  b_wpar,
  output logic [B_DW-1:0]   b_rdata,
  output logic [B_PPW-1:0]  b_rpar
);

  logic [ROW_AW-1:0] a_row, b_row;
  logic [ROW_W-1:0]  a_bank_d, b_bank_d;
  logic [ROW_PW-1:0] a_bank_p, b_bank_p;
  logic              a_fire, b_fire;

  assign a_fire = a_act & a_write;
  assign b_fire = b_act & b_write;

  mwdp_port #(.DW(A_DW), .VIEW(A_VIEW)) u_port_a (
    .clk     (a_clk),
    .srst    (a_srst),
    .en      (a_act),
    .wr      (a_write),
    .loc     (a_loc),
    .wdata   (a_wdata),
    .wpar    (a_wpar),
    .rdata   (a_rdata),
    .rpar    (a_rpar),
    .my_row  (a_row),
    .peer_d  (b_bank_d),
    .peer_p  (b_bank_p),
    .xrow    (b_row),
    .xrow_d  (a_bank_d),
    .xrow_p  (a_bank_p),
    .peer_wr (b_fire)
  );

  mwdp_port #(.DW(B_DW), .VIEW(B_VIEW)) u_port_b (
    .clk     (b_clk),
    .srst    (b_srst),
    .en      (b_act),
    .wr      (b_write),
    .loc     (b_loc),
    .wdata   (b_wdata),
    .wpar    (b_wpar),
    .rdata   (b_rdata),
    .rpar    (b_rpar),
    .my_row  (b_row),
    .peer_d  (a_bank_d),
    .peer_p  (a_bank_p),
    .xrow    (a_row),
    .xrow_d  (b_bank_d),
    .xrow_p  (b_bank_p),
    .peer_wr (a_fire)
  );

endmodule

// File: tb/tb_mixwidth_dpram.sv
module tb_mixwidth_dpram;
  import mwdp_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int A_DW = 4;
  localparam int B_DW = 16;
  localparam int A_LW = 12;
  localparam int B_LW = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            a_srst, a_act, a_write;
  logic [A_LW-1:0] a_loc;
  logic [3:0]      a_wdata;
  logic [0:0]      a_wpar;
  logic [3:0]      a_rdata;
  logic [0:0]      a_rpar;
  logic            b_srst, b_act, b_write;
  logic [B_LW-1:0] b_loc;
  logic [15:0]     b_wdata;
  logic [1:0]      b_wpar;
  logic [15:0]     b_rdata;
  logic [1:0]      b_rpar;

  mixwidth_dpram #(.A_DW(A_DW), .A_VIEW(VIEW_NEW), .B_DW(B_DW), .B_VIEW(VIEW_OLD)) dut (
    .a_clk(clk), .a_srst(a_srst), .a_act(a_act), .a_write(a_write), .a_loc(a_loc),
    .a_wdata(a_wdata), .a_wpar(a_wpar), .a_rdata(a_rdata), .a_rpar(a_rpar),
    .b_clk(clk), .b_srst(b_srst), .b_act(b_act), .b_write(b_write), .b_loc(b_loc),
    .b_wdata(b_wdata), .b_wpar(b_wpar), .b_rdata(b_rdata), .b_rpar(b_rpar)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag   = "R9";

  // Flat reference store: bit i of data, bit k of parity (byte k).
  logic [16383:0] ref_d = '0;
  logic [2047:0]  ref_p = '0;
  logic [3:0]     exp_ad = '0;
  logic [0:0]     exp_ap = '0;
  logic [15:0]    exp_bd = '0;
  logic [1:0]     exp_bp = '0;

  always @(posedge clk) begin : model
    logic [16383:0] od;
    logic [2047:0]  op;
    od = ref_d;
    op = ref_p;
    if (a_srst) begin
      exp_ad = '0; exp_ap = '0;
    end else if (a_act) begin
      exp_ad = a_write ? a_wdata : od[int'(a_loc)*4 +: 4];   // new-data view
      exp_ap = '0;
    end
    if (b_srst) begin
      exp_bd = '0; exp_bp = '0;
    end else if (b_act) begin
      exp_bd = od[int'(b_loc)*16 +: 16];                      // old-data view
      exp_bp = op[int'(b_loc)*2 +: 2];
    end
    if (a_act && a_write) ref_d[int'(a_loc)*4 +: 4] = a_wdata;
    if (b_act && b_write) begin
      ref_d[int'(b_loc)*16 +: 16] = b_wdata;
      ref_p[int'(b_loc)*2 +: 2]   = b_wpar;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic step(input logic ea, input logic wa, input int la, input logic [3:0] da,
                      input logic eb, input logic wb, input int lb, input logic [15:0] db,
                      input logic [1:0] pb, input string t);
    a_act = ea; a_write = wa; a_loc = A_LW'(la); a_wdata = da; a_wpar = 1'b1;
    b_act = eb; b_write = wb; b_loc = B_LW'(lb); b_wdata = db; b_wpar = pb;
    tag = t;
    @(posedge clk);
    @(negedge clk);
    n_vec++;
    if (a_rdata !== exp_ad || a_rpar !== exp_ap || b_rdata !== exp_bd || b_rpar !== exp_bp) begin
      n_bad++;
      $display("FAIL %s: actual a=%h/%h b=%h/%h expected a=%h/%h b=%h/%h", tag,
               a_rdata, a_rpar, b_rdata, b_rpar, exp_ad, exp_ap, exp_bd, exp_bp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog (all of R1..R11): actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    a_srst = 1'b1; b_srst = 1'b1;
    // R9: reset state of the read outputs
    step(0, 0, 0, 4'h0, 0, 0, 0, 16'h0, 2'b00, "R9 reset");
    step(1, 0, 0, 4'h0, 1, 0, 0, 16'h0, 2'b00, "R9 reset");
    a_srst = 1'b0; b_srst = 1'b0;

    // R11: unwritten locations read zero
    step(1, 0, 5, 4'h0, 1, 0, 77, 16'h0, 2'b00, "R11 zero store");

    // R2, R7: narrow writes packed into a wide read
    for (int i = 0; i < 8; i++)
      step(1, 1, i, 4'(i + 1), 0, 0, 0, 16'h0, 2'b00, "R2 narrow write");
    step(0, 0, 0, 4'h0, 1, 0, 0, 16'h0, 2'b00, "R7 packed read lo");
    step(0, 0, 0, 4'h0, 1, 0, 1, 16'h0, 2'b00, "R7 packed read hi");

    // R3: plain reads on both ports
    step(1, 0, 2, 4'h0, 1, 0, 0, 16'h0, 2'b00, "R3 plain read");

    // R5: new-data view echoes
    step(1, 1, 9, 4'hA, 0, 0, 0, 16'h0, 2'b00, "R5 write echo");

    // R6: old-data view on write, then readback with parity
    step(0, 0, 0, 4'h0, 1, 0, 700, 16'h0, 2'b00, "R6 pre-read");
    step(0, 0, 0, 4'h0, 1, 1, 700, 16'hBEEF, 2'b10, "R6 old on write");
    step(0, 0, 0, 4'h0, 1, 0, 700, 16'h0, 2'b00, "R2 wide readback");

    // R8: wide word split in nibbles, narrow write keeps parity
    for (int i = 0; i < 4; i++)
      step(1, 0, 2800 + i, 4'h0, 0, 0, 0, 16'h0, 2'b00, "R7 split read");
    step(1, 1, 2801, 4'h3, 0, 0, 0, 16'h0, 2'b00, "R8 narrow write");
    step(0, 0, 0, 4'h0, 1, 0, 700, 16'h0, 2'b00, "R8 parity kept");
    step(0, 0, 0, 4'h0, 1, 1, 701, 16'h1357, 2'b01, "R8 parity lane");
    step(0, 0, 0, 4'h0, 1, 0, 701, 16'h0, 2'b00, "R8 parity lane read");

    // R4: disabled ports ignore write strobes
    step(0, 1, 0, 4'hF, 0, 1, 0, 16'hFFFF, 2'b11, "R4 idle hold");
    step(1, 0, 0, 4'h0, 1, 0, 0, 16'h0, 2'b00, "R4 nothing stored");

    // R10: read of pre-edge contents, disjoint simultaneous writes
    step(1, 1, 16, 4'h9, 1, 0, 4, 16'h0, 2'b00, "R10 read vs peer write");
    step(0, 0, 0, 4'h0, 1, 0, 4, 16'h0, 2'b00, "R10 after peer write");
    step(1, 1, 20, 4'h6, 1, 1, 6, 16'h2468, 2'b11, "R10 dual write");
    step(1, 0, 24, 4'h0, 1, 0, 5, 16'h0, 2'b00, "R10 dual readback");

    // R9: reset clears output but the write still lands
    b_srst = 1'b1;
    step(0, 0, 0, 4'h0, 1, 1, 8, 16'h1234, 2'b01, "R9 reset with write");
    b_srst = 1'b0;
    step(0, 0, 0, 4'h0, 1, 0, 8, 16'h0, 2'b00, "R9 write kept");

    // R1: top of each location range, parity pin of a narrow port
    step(0, 0, 0, 4'h0, 1, 1, 1023, 16'hC0DE, 2'b11, "R1 top wide");
    step(1, 0, 4095, 4'h0, 0, 0, 0, 16'h0, 2'b00, "R1 top narrow");
    step(1, 1, 4094, 4'h5, 0, 0, 0, 16'h0, 2'b00, "R1 narrow parity zero");

    // R7, R10: mixed traffic, A writes low half, B writes high half
    for (int i = 0; i < 400; i++) begin
      logic ea, wa, eb, wb;
      int   la, lb;
      ea = 1'($urandom_range(0, 3) != 0);
      wa = 1'($urandom_range(0, 1));
      eb = 1'($urandom_range(0, 3) != 0);
      wb = 1'($urandom_range(0, 1));
      la = wa ? int'($urandom_range(0, 2047)) : int'($urandom_range(0, 4095));
      lb = wb ? int'($urandom_range(512, 1023)) : int'($urandom_range(0, 1023));
      step(ea, wa, la, 4'($urandom), eb, wb, lb, 16'($urandom), 2'($urandom), "R7 mixed");
    end

    summary();
    $finish;
  end

endmodule